// File: doc/BRIEF.md
# Two-way software-refilled address translation cache

This block turns a 40-bit virtual address into a 36-bit physical address. Pages are 16 KB, so the low 14 address bits pass through unchanged and the 26-bit virtual page number is looked up. The translation store holds 512 entries, organised as 256 sets of two ways. Each entry carries a valid flag, a dirty flag, a referenced flag, a 2-bit rights code, an 18-bit tag and a 22-bit physical page number. A lookup compares both ways of the indexed set in parallel in a single cycle. It returns one of four results: a translated address, a miss, a protection fault, or a duplicate-entry error.

The block never walks a page table. A miss is reported to the caller, and trap software then installs the translation through a privileged maintenance port. The same port can remove one translation, drop every translation, or clear every referenced flag in a single step. Hardware sets the dirty flag when a write is allowed, because pages are written back. It sets the referenced flag on every successful translation. Software clears the referenced flags at intervals to estimate which pages are in use.

Top module: `xlt_tlb`

## Requirements
- R1: On a hit, `lk_paddr` is the entry's 22-bit page number followed by `lk_vaddr[13:0]`. Set index is `lk_vaddr[21:14]` and tag is `lk_vaddr[39:22]`. The result is combinational in the same cycle as the request.
- R2: When `lk_valid` is high and no valid way of the indexed set holds the tag, `lk_miss` is 1, `lk_hit` is 0 and `lk_paddr` is 0.
- R3: At most one of `lk_hit`, `lk_miss`, `lk_fault` is high. All of the lookup outputs are 0 while `lk_valid` is low.
- R4: Rights code 0 forbids all access. Code 1 allows reads only. Code 2 allows reads and writes. Code 3 allows reads and writes only when `lk_user` is 0. A single matching entry whose rights forbid the request gives `lk_fault` = 1, `lk_hit` = 0 and `lk_paddr` = 0.
- R5: An allowed write hit sets the entry's dirty flag, and a fault never does. On a hit, `lk_dirty` shows the flag as stored before this lookup's update.
- R6: Every hit sets the entry's referenced flag, and `lk_ref` shows the stored value on a hit. Maintenance op 4 clears every referenced flag.
- R7: Each set keeps one replacement bit, and a hit makes the other way the replacement candidate. A fill (op 1) with `sw_way_en` = 0 goes to way 0 if way 0 is invalid. Otherwise it goes to way 1 if way 1 is invalid. Otherwise it goes to the replacement candidate. The filled way then becomes the most recent way.
- R8: A fill with `sw_way_en` = 1 writes way `sw_way`. The entry takes its tag and set from `sw_vpn`, its page number from `sw_ppn`, its rights from `sw_rights` and its dirty flag from `sw_dirty`, and its referenced flag starts at 0.
- R9: Op 2 invalidates every way of set `sw_vpn[7:0]` whose tag equals `sw_vpn[25:8]`. Op 3 invalidates all entries.
- R10: A maintenance op takes effect at the next clock edge, and a lookup in the same cycle sees the old contents. When a lookup update and a maintenance op touch the same flag at one edge, the maintenance op wins.
- R11: If both ways of the set match the tag, `lk_multi` and `lk_miss` are 1, `lk_hit` and `lk_fault` are 0, and no flag or replacement bit changes.
- R12: After reset, every entry is invalid and every replacement bit points at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 40 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No usable entry; trap to refill software |
| lk_fault | output | 1 | Entry found but rights forbid the access |
| lk_multi | output | 1 | Both ways matched (error) |
| lk_paddr | output | 36 | Physical address on hit, else 0 |
| lk_dirty | output | 1 | Stored dirty flag of the hit entry |
| lk_ref | output | 1 | Stored referenced flag of the hit entry |
| sw_op | input | 3 | 0 none, 1 fill, 2 invalidate, 3 invalidate all, 4 clear referenced flags |
| sw_vpn | input | 26 | Virtual page number for fill or invalidate |
| sw_way_en | input | 1 | Fill uses `sw_way` instead of automatic choice |
| sw_way | input | 1 | Explicit fill way |
| sw_ppn | input | 22 | Physical page number for fill |
| sw_rights | input | 2 | Rights code for fill |
| sw_dirty | input | 1 | Initial dirty flag for fill |

## Verification
Directed sequences use one set per rights code and try every combination of read or write with user or kernel mode. This separates the fault decisions from one another and from plain hits. Repeated fills into a single set, with and without an explicit way and with hits between them, show whether the victim follows the invalid-first and then least-recent order. Lookups issued in the same cycle as fills, clears and invalidations show that reads see the old contents and that maintenance wins on shared flags. A long random mix over a few sets and tags covers refills, duplicates and write-backs, and a behavioural model checks every output on every cycle.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int WAYS = 2;

    localparam logic [2:0] OP_NOP    = 3'd0;
    localparam logic [2:0] OP_FILL   = 3'd1;
    localparam logic [2:0] OP_INVAL  = 3'd2;
    localparam logic [2:0] OP_FLUSH  = 3'd3;
    localparam logic [2:0] OP_CLRREF = 3'd4;

    localparam logic [1:0] RG_NONE = 2'd0;
    localparam logic [1:0] RG_RO   = 2'd1;
    localparam logic [1:0] RG_RW   = 2'd2;
    localparam logic [1:0] RG_KRW  = 2'd3;
endpackage

// File: rtl/xlt_way_cmp.sv
module xlt_way_cmp
    import xlt_pkg::*;
#(
    parameter int TAG_W = 18
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = vld[w] && (tags[w] == tag);
    end
endmodule

// File: rtl/xlt_rights_chk.sv
module xlt_rights_chk
    import xlt_pkg::*;
(
    input  logic [1:0] rights,
    input  logic       is_write,
    input  logic       is_user,
    output logic       allow
);
    always_comb begin
        unique case (rights)
            RG_NONE: allow = 1'b0;
            RG_RO:   allow = !is_write;
            RG_RW:   allow = 1'b1;
            default: allow = !is_user;
        endcase
    end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim
    import xlt_pkg::*;
(
    input  logic [WAYS-1:0] vld,
    input  logic            lru,
    input  logic            force_en,
    input  logic            force_way,
    output logic            way
);
    always_comb begin
        if (force_en)       way = force_way;
        else if (!vld[0])   way = 1'b0;
        else if (!vld[1])   way = 1'b1;
        else                way = lru;
    end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
    import xlt_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int OFF_W = 14,
    parameter int IDX_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_vaddr,
    input  logic                    lk_write,
    input  logic                    lk_user,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic                    lk_fault,
    output logic                    lk_multi,
    output logic [PA_W-1:0]         lk_paddr,
    output logic                    lk_dirty,
    output logic                    lk_ref,
    input  logic [2:0]              sw_op,
    input  logic [VA_W-OFF_W-1:0]   sw_vpn,
    input  logic                    sw_way_en,
    input  logic                    sw_way,
    input  logic [PA_W-OFF_W-1:0]   sw_ppn,
    input  logic [1:0]              sw_rights,
    input  logic                    sw_dirty
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0]            dty;
        logic [SETS-1:0][WAYS-1:0]            rfd;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn;
        logic [SETS-1:0][WAYS-1:0][1:0]       rgt;
        logic [SETS-1:0]                      lru;
    } state_t;

    state_t st_d, st_q;

    // lookup side
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  match;
    logic             one_match, two_match, hit_way, allow;

    assign lk_idx = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];

    xlt_way_cmp #(.TAG_W(TAG_W)) u_cmp (
        .vld   (st_q.vld[lk_idx]),
        .tags  (st_q.tag[lk_idx]),
        .tag   (lk_tag),
        .match (match)
    );

    assign two_match = &match;
    assign one_match = ^match;
    assign hit_way   = match[1];

    xlt_rights_chk u_chk (
        .rights   (st_q.rgt[lk_idx][hit_way]),
        .is_write (lk_write),
        .is_user  (lk_user),
        .allow    (allow)
    );

    always_comb begin
        lk_hit   = lk_valid && one_match && allow;
        lk_fault = lk_valid && one_match && !allow;
        lk_miss  = lk_valid && !one_match;
        lk_multi = lk_valid && two_match;
        lk_paddr = lk_hit ? {st_q.ppn[lk_idx][hit_way], lk_vaddr[OFF_W-1:0]} : '0;
        lk_dirty = lk_hit && st_q.dty[lk_idx][hit_way];
        lk_ref   = lk_hit && st_q.rfd[lk_idx][hit_way];
    end

    // maintenance side
    logic [IDX_W-1:0] sw_idx;
    logic [TAG_W-1:0] sw_tag;
    logic             fill_way;

    assign sw_idx = sw_vpn[IDX_W-1:0];
    assign sw_tag = sw_vpn[VPN_W-1 -: TAG_W];

    xlt_victim u_vic (
        .vld       (st_q.vld[sw_idx]),
        .lru       (st_q.lru[sw_idx]),
        .force_en  (sw_way_en),
        .force_way (sw_way),
        .way       (fill_way)
    );

    // next state: lookup effects first, maintenance overrides
    always_comb begin
        st_d = st_q;
        if (lk_hit) begin
            st_d.rfd[lk_idx][hit_way] = 1'b1;
            st_d.lru[lk_idx]          = !hit_way;
            if (lk_write) st_d.dty[lk_idx][hit_way] = 1'b1;
        end
        unique case (sw_op)
            OP_FILL: begin
                st_d.vld[sw_idx][fill_way] = 1'b1;
                st_d.tag[sw_idx][fill_way] = sw_tag;
                st_d.ppn[sw_idx][fill_way] = sw_ppn;
                st_d.rgt[sw_idx][fill_way] = sw_rights;
                st_d.dty[sw_idx][fill_way] = sw_dirty;
                st_d.rfd[sw_idx][fill_way] = 1'b0;
                st_d.lru[sw_idx]           = !fill_way;
            end
            OP_INVAL: begin
                for (int w = 0; w < WAYS; w++) begin
                    if (st_q.vld[sw_idx][w] && st_q.tag[sw_idx][w] == sw_tag)
                        st_d.vld[sw_idx][w] = 1'b0;
                end
            end
            OP_FLUSH:  st_d.vld = '0;
            OP_CLRREF: st_d.rfd = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: result classes are exclusive
    a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R11: duplicate match is never a hit
    a_r11_multi_miss: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> (lk_miss && !lk_hit && !lk_fault));

    // R5: allowed write hit leaves the entry dirty
    a_r5_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && sw_op == OP_NOP) |=>
        st_q.dty[$past(lk_idx)][$past(hit_way)]);

    // R5: a fault leaves the dirty flag untouched
    a_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && sw_op == OP_NOP) |=>
        (st_q.dty[$past(lk_idx)][$past(hit_way)] == $past(st_q.dty[lk_idx][hit_way])));

    // R9: invalidate-all empties the store
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op == OP_FLUSH) |=> (st_q.vld == '0));

    // R8: explicit fill makes the chosen way valid
    a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op == OP_FILL && sw_way_en) |=> st_q.vld[$past(sw_idx)][$past(sw_way)]);
endmodule

// File: tb/xlt_tlb_tb.sv
module xlt_tlb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [39:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_multi, lk_dirty, lk_ref;
    logic [35:0] lk_paddr;
    logic [2:0]  sw_op = 3'd0;
    logic [25:0] sw_vpn = '0;
    logic        sw_way_en = 1'b0, sw_way = 1'b0, sw_dirty = 1'b0;
    logic [21:0] sw_ppn = '0;
    logic [1:0]  sw_rights = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlt_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_multi(lk_multi),
        .lk_paddr(lk_paddr), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .sw_op(sw_op), .sw_vpn(sw_vpn), .sw_way_en(sw_way_en), .sw_way(sw_way),
        .sw_ppn(sw_ppn), .sw_rights(sw_rights), .sw_dirty(sw_dirty)
    );

    // behavioural reference store
    bit        mv [SETS][2];
    bit [17:0] mt [SETS][2];
    bit [21:0] mp [SETS][2];
    bit [1:0]  mr [SETS][2];
    bit        md [SETS][2];
    bit        mf [SETS][2];
    bit        ml [SETS];

    task automatic cmp(string req, string fld, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, fld, act, exp, $time);
        end
    endtask

    function automatic bit [39:0] mkva(bit [17:0] tg, bit [7:0] ix, bit [13:0] off);
        return {tg, ix, off};
    endfunction

    task automatic step(string req, bit lv, bit [39:0] va, bit wr, bit us,
                        bit [2:0] op, bit [25:0] vpn, bit wen, bit wy,
                        bit [21:0] ppn, bit [1:0] rg, bit dy);
        int idx, n, w, si, ch;
        bit [17:0] tg;
        bit ok, e_hit, e_fault, e_miss, e_multi, e_d, e_r;
        bit [35:0] e_pa;
        lk_valid = lv; lk_vaddr = va; lk_write = wr; lk_user = us;
        sw_op = op; sw_vpn = vpn; sw_way_en = wen; sw_way = wy;
        sw_ppn = ppn; sw_rights = rg; sw_dirty = dy;
        #1;
        idx = int'(va[21:14]); tg = va[39:22]; n = 0; w = 0;
        for (int k = 0; k < 2; k++)
            if (mv[idx][k] && mt[idx][k] == tg) begin n++; w = k; end
        case (mr[idx][w])
            2'd0: ok = 0;
            2'd1: ok = !wr;
            2'd2: ok = 1;
            default: ok = !us;
        endcase
        e_multi = lv && n == 2;
        e_hit   = lv && n == 1 && ok;
        e_fault = lv && n == 1 && !ok;
        e_miss  = lv && n != 1;
        e_pa    = e_hit ? {mp[idx][w], va[13:0]} : 36'd0;
        e_d     = e_hit && md[idx][w];
        e_r     = e_hit && mf[idx][w];
        cmp(req, "hit", lk_hit, e_hit);
        cmp(req, "miss", lk_miss, e_miss);
        cmp(req, "fault", lk_fault, e_fault);
        cmp(req, "multi", lk_multi, e_multi);
        cmp(req, "paddr", lk_paddr, e_pa);
        cmp(req, "dirty", lk_dirty, e_d);
        cmp(req, "ref", lk_ref, e_r);
        @(posedge clk);
        if (e_hit) begin
            mf[idx][w] = 1;
            ml[idx] = (w == 0);
            if (wr) md[idx][w] = 1;
        end
        si = int'(vpn[7:0]);
        case (op)
            3'd1: begin
                if (wen) ch = wy;
                else if (!mv[si][0]) ch = 0;
                else if (!mv[si][1]) ch = 1;
                else ch = ml[si];
                mv[si][ch] = 1; mt[si][ch] = vpn[25:8]; mp[si][ch] = ppn;
                mr[si][ch] = rg; md[si][ch] = dy; mf[si][ch] = 0;
                ml[si] = (ch == 0);
            end
            3'd2: for (int k = 0; k < 2; k++)
                      if (mv[si][k] && mt[si][k] == vpn[25:8]) mv[si][k] = 0;
            3'd3: foreach (mv[a, b]) mv[a][b] = 0;
            3'd4: foreach (mf[a, b]) mf[a][b] = 0;
            default: ;
        endcase
        @(negedge clk);
    endtask

    task automatic look(string req, bit [39:0] va, bit wr, bit us);
        step(req, 1, va, wr, us, 3'd0, '0, 0, 0, '0, '0, 0);
    endtask

    task automatic fill(string req, bit [17:0] tg, bit [7:0] ix, bit wen, bit wy,
                        bit [21:0] ppn, bit [1:0] rg, bit dy);
        step(req, 0, '0, 0, 0, 3'd1, {tg, ix}, wen, wy, ppn, rg, dy);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        foreach (mv[a, b]) begin mv[a][b] = 0; md[a][b] = 0; mf[a][b] = 0; end
        foreach (ml[a]) ml[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: empty after reset
        look("R12", mkva(18'h0, 8'h00, 14'h0), 0, 0);
        look("R12", mkva(18'h3FFFF, 8'hFF, 14'h3FFF), 1, 1);
        look("R2", mkva(18'h00123, 8'h05, 14'h1234), 0, 0);
        step("R3", 0, mkva(18'h1, 8'h1, 14'h1), 0, 0, 3'd0, '0, 0, 0, '0, '0, 0);

        // R10: fill with same-cycle lookup sees old contents
        step("R10", 1, mkva(18'h00123, 8'h05, 14'h1234), 0, 0,
             3'd1, {18'h00123, 8'h05}, 0, 0, 22'h2ABCD, 2'd2, 0);
        // R1: translated address
        look("R1", mkva(18'h00123, 8'h05, 14'h1234), 0, 0);
        look("R1", mkva(18'h00123, 8'h05, 14'h3FFF), 0, 1);
        look("R2", mkva(18'h00124, 8'h05, 14'h0), 0, 0);

        // R4: rights table
        for (int r = 0; r < 4; r++)
            fill("R8", 18'h00A00 + 18'(r), 8'h10 + 8'(r), 0, 0, 22'h100 + 22'(r), 2'(r), 0);
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                look("R4", mkva(18'h00A00 + 18'(r), 8'h10 + 8'(r), 14'h0055), m[0], m[1]);

        // R5: dirty on allowed write, not on fault
        look("R5", mkva(18'h00A02, 8'h12, 14'h0), 0, 0);
        look("R5", mkva(18'h00A01, 8'h11, 14'h0), 1, 0);
        look("R5", mkva(18'h00A01, 8'h11, 14'h0), 0, 0);

        // R6: referenced flag, bulk clear
        look("R6", mkva(18'h00123, 8'h05, 14'h0), 0, 0);
        step("R6", 0, '0, 0, 0, 3'd4, '0, 0, 0, '0, '0, 0);
        look("R6", mkva(18'h00123, 8'h05, 14'h0), 0, 0);
        look("R6", mkva(18'h00123, 8'h05, 14'h0), 0, 0);
        // R10: clear in same cycle as a hit wins
        step("R10", 1, mkva(18'h00123, 8'h05, 14'h0), 0, 0, 3'd4, '0, 0, 0, '0, '0, 0);
        look("R10", mkva(18'h00123, 8'h05, 14'h0), 0, 0);

        // R7: victim order
        fill("R7", 18'h0000A, 8'h20, 0, 0, 22'h0A, 2'd2, 0);
        fill("R7", 18'h0000B, 8'h20, 0, 0, 22'h0B, 2'd2, 0);
        look("R7", mkva(18'h0000A, 8'h20, 14'h0), 0, 0);
        fill("R7", 18'h0000C, 8'h20, 0, 0, 22'h0C, 2'd2, 1);
        look("R7", mkva(18'h0000B, 8'h20, 14'h0), 0, 0);
        look("R7", mkva(18'h0000A, 8'h20, 14'h0), 0, 0);
        look("R7", mkva(18'h0000C, 8'h20, 14'h0), 0, 0);
        fill("R7", 18'h0000E, 8'h20, 0, 0, 22'h0E, 2'd2, 0);
        look("R7", mkva(18'h0000A, 8'h20, 14'h0), 0, 0);
        look("R7", mkva(18'h0000E, 8'h20, 14'h0), 0, 0);

        // R8: explicit way
        fill("R8", 18'h0000D, 8'h20, 1, 1, 22'h0D, 2'd1, 1);
        look("R8", mkva(18'h0000D, 8'h20, 14'h7), 0, 0);
        look("R8", mkva(18'h0000C, 8'h20, 14'h7), 0, 0);

        // R9: single invalidate
        step("R9", 0, '0, 0, 0, 3'd2, {18'h0000D, 8'h20}, 0, 0, '0, '0, 0);
        look("R9", mkva(18'h0000D, 8'h20, 14'h0), 0, 0);
        look("R9", mkva(18'h0000E, 8'h20, 14'h0), 0, 0);

        // R11: duplicate entries
        fill("R11", 18'h00055, 8'h30, 1, 0, 22'h1, 2'd2, 0);
        fill("R11", 18'h00055, 8'h30, 1, 1, 22'h2, 2'd2, 0);
        look("R11", mkva(18'h00055, 8'h30, 14'h0), 1, 0);
        step("R9", 0, '0, 0, 0, 3'd2, {18'h00055, 8'h30}, 0, 0, '0, '0, 0);
        look("R11", mkva(18'h00055, 8'h30, 14'h0), 0, 0);

        // R9: invalidate all
        step("R9", 1, mkva(18'h00123, 8'h05, 14'h0), 0, 0, 3'd3, '0, 0, 0, '0, '0, 0);
        look("R9", mkva(18'h00123, 8'h05, 14'h0), 0, 0);
        look("R9", mkva(18'h00A02, 8'h12, 14'h0), 0, 0);

        // R3: random mix over a few sets and tags
        for (int i = 0; i < 4000; i++) begin
            bit [7:0]  ix = 8'($urandom_range(0, 3));
            bit [17:0] tg = 18'($urandom_range(0, 3));
            int        sel = $urandom_range(0, 99);
            bit [2:0]  op;
            if (sel < 20) op = 3'd1;
            else if (sel < 25) op = 3'd2;
            else if (sel < 26) op = 3'd3;
            else if (sel < 28) op = 3'd4;
            else op = 3'd0;
            step("R3", 1'($urandom_range(0, 4) != 0),
                 mkva(18'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 14'($urandom)),
                 1'($urandom), 1'($urandom), op, {tg, ix},
                 1'($urandom_range(0, 5) == 0), 1'($urandom),
                 22'($urandom), 2'($urandom), 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule